// File: doc/BRIEF.md
# FPGA Passive-Parallel Configuration Sequencer

This block runs the pin handshake that brings a target FPGA from power-up to user mode over a passive-parallel configuration port. A one-cycle start pulse begins a run. The block first checks the strapped mode-select value. It waits for the board-level reset and status lines to read high, then takes control of the configuration pins in a fixed order. It applies a reset pulse on the reset line and checks that the target has reacted. It then opens the data path while an external mover streams bitstream words. When the target reports that configuration is complete, the block issues the extra trailing clock pulses. It waits for user mode, hands the pins back and makes a final health check.

Every wait step has its own timeout. Each failure point has its own error code, and that code stays on the outputs until the next start pulse. Software or a boot controller only needs to pulse start, wait for busy to drop, and then read done and the error code.

Top module: `cfg_seq`

## Requirements
- R1: After start, a mode-select value of 0 or 1 lets the run proceed. Any value from 2 to 7 ends the run in the next cycle with error code 1, and the override output never rises.
- R2: The override is taken only after the reset-line and status inputs both read high. If they do not both read high within TIMEOUT cycles, the run fails with code 2. After chip select goes low the same wait is repeated, and its timeout gives code 3.
- R3: In the first cycle that the override is high, nce_o is 1, nconfig_o is 1, and data_en_o and ctrl_en_o are 0. nce_o falls exactly one cycle later. pr_req_o, ns_oe_o and cd_oe_o are always 0.
- R4: The reset step holds nconfig_o low until the status input reads low, with code 4 on timeout. It then drives nconfig_o high until status reads high again, with code 5 on timeout.
- R5: After the reset step, a configuration-done input that reads high gives code 6. A configuration-done drive-enable input that reads low gives code 7. Otherwise data_en_o and ctrl_en_o rise together.
- R6: While waiting for configuration-done, a low status input gives code 8 and a timeout gives code 9. If configuration-done and a low status arrive in the same cycle, configuration-done wins and the run continues.
- R7: After configuration-done, exactly 15 dclk_o pulses are issued before user mode is awaited. Each pulse is one cycle high and is followed by at least one cycle low.
- R8: If user mode is not seen within TIMEOUT cycles, the run fails with code 10. Once user mode is seen, the enables drop, the override is released and nce_o returns to 1.
- R9: The final check needs user mode, configuration-done and status all high. If it passes, done_o goes to 1 with code 0. If it fails, the run gives code 11.
- R10: Error code and done_o hold their values while idle until the next start pulse. A start pulse during a run is ignored. On any failure the pins return to their released state: override 0, nce_o 1, nconfig_o 1, enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle run request |
| msel_i | input | 3 | Strapped mode-select value |
| nconfig_pin_i | input | 1 | Sensed level of the reset line |
| nstatus_pin_i | input | 1 | Sensed level of the status line |
| conf_done_pin_i | input | 1 | Sensed configuration-done line |
| conf_done_oe_i | input | 1 | Sensed drive-enable of configuration-done |
| user_mode_i | input | 1 | Target reports user mode |
| ovr_o | output | 1 | Pin override taken |
| nconfig_o | output | 1 | Driven reset line level |
| nce_o | output | 1 | Chip select, active low |
| pr_req_o | output | 1 | Partial-reconfiguration request, held low |
| ns_oe_o | output | 1 | Status line drive enable, held low |
| cd_oe_o | output | 1 | Configuration-done drive enable, held low |
| data_en_o | output | 1 | Data path enable |
| ctrl_en_o | output | 1 | Control path and clock enable |
| dclk_o | output | 1 | Trailing configuration clock pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run succeeded |
| err_o | output | 4 | Failure code of the last run, 0 if none |

## Verification
The two events that can fall in one cycle are configuration-done rising and the status line dropping while the block waits for configuration to finish. The bench's target model can drop status for exactly the cycle in which its data counter makes configuration-done rise. The expected result is a completed run with code 0 and 15 trailing pulses. A second case drops status ten data cycles earlier, and that run must end with code 8 and the data path closed.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int ERR_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MSEL, ST_WAIT_A, ST_TAKE, ST_SEL, ST_WAIT_B, ST_RST_LO,
    ST_RST_HI, ST_RST_CHK, ST_WAIT_CD, ST_DCLK, ST_WAIT_UM, ST_RELEASE, ST_FINAL
  } state_e;

  typedef enum logic [ERR_W-1:0] {
    E_NONE      = 4'd0,
    E_MSEL      = 4'd1,
    E_IDLE_PINS = 4'd2,
    E_SEL_PINS  = 4'd3,
    E_NS_LO_TMO = 4'd4,
    E_NS_HI_TMO = 4'd5,
    E_CD_EARLY  = 4'd6,
    E_CD_OE     = 4'd7,
    E_NS_DROP   = 4'd8,
    E_CD_TMO    = 4'd9,
    E_UM_TMO    = 4'd10,
    E_FINAL     = 4'd11
  } err_e;

  typedef struct packed {
    logic nce;
    logic nconfig;
    logic data_en;
    logic ctrl_en;
    logic ovr;
  } pins_t;

  localparam pins_t PINS_REST = '{nce: 1'b1, nconfig: 1'b1, data_en: 1'b0,
                                  ctrl_en: 1'b0, ovr: 1'b0};
endpackage

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int TIMEOUT = 1 << 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= RELOAD;
    else if (load_i)           cnt_q <= RELOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_seq_dclk.sv
module cfg_seq_dclk #(
  parameter int PULSES = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic dclk_o,
  output logic done_o
);
  localparam int CW = $clog2(PULSES + 1);

  logic [CW-1:0] left_q;
  logic          run_q;
  logic          dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      run_q  <= 1'b0;
      dclk_q <= 1'b0;
    end else if (start_i) begin
      left_q <= CW'(PULSES);
      run_q  <= 1'b1;
      dclk_q <= 1'b0;
    end else if (run_q) begin
      if (!dclk_q && left_q != '0) begin
        dclk_q <= 1'b1;
        left_q <= left_q - 1'b1;
      end else begin
        dclk_q <= 1'b0;
        if (!dclk_q && left_q == '0) run_q <= 1'b0;
      end
    end
  end

  assign dclk_o = dclk_q;
  assign done_o = run_q && !dclk_q && (left_q == '0);

  AST_DCLK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |=> !dclk_o); // R7
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int TIMEOUT = 1 << 24,
  parameter int PULSES  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       msel_i,
  input  logic             nconfig_pin_i,
  input  logic             nstatus_pin_i,
  input  logic             conf_done_pin_i,
  input  logic             conf_done_oe_i,
  input  logic             user_mode_i,
  output logic             ovr_o,
  output logic             nconfig_o,
  output logic             nce_o,
  output logic             pr_req_o,
  output logic             ns_oe_o,
  output logic             cd_oe_o,
  output logic             data_en_o,
  output logic             ctrl_en_o,
  output logic             dclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);
  state_e state_q, state_d;
  err_e   err_q, err_d, fcode;
  pins_t  pin_q, pin_d;
  logic   done_q, done_d;
  logic   fail, tmr_load, tmr_exp, dclk_go, dclk_done, pins_hi;

  cfg_seq_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .expired_o(tmr_exp)
  );

  cfg_seq_dclk #(.PULSES(PULSES)) u_dclk (
    .clk_i, .rst_ni, .start_i(dclk_go), .dclk_o, .done_o(dclk_done)
  );

  assign pins_hi = nconfig_pin_i && nstatus_pin_i;

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    done_d   = done_q;
    pin_d    = pin_q;
    tmr_load = 1'b0;
    dclk_go  = 1'b0;
    fail     = 1'b0;
    fcode    = E_NONE;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_MSEL;
        err_d   = E_NONE;
        done_d  = 1'b0;
      end
      ST_MSEL: if (msel_i > 3'd1) begin
        fail = 1'b1; fcode = E_MSEL;
      end else begin
        state_d = ST_WAIT_A; tmr_load = 1'b1;
      end
      ST_WAIT_A: if (pins_hi) state_d = ST_TAKE;
                 else if (tmr_exp) begin fail = 1'b1; fcode = E_IDLE_PINS; end
      ST_TAKE: begin
        pin_d   = '{nce: 1'b1, nconfig: 1'b1, data_en: 1'b0, ctrl_en: 1'b0, ovr: 1'b1};
        state_d = ST_SEL;
      end
      ST_SEL: begin
        pin_d.nce = 1'b0;
        state_d   = ST_WAIT_B;
        tmr_load  = 1'b1;
      end
      ST_WAIT_B: if (pins_hi) begin
        pin_d.nconfig = 1'b0; state_d = ST_RST_LO; tmr_load = 1'b1;
      end else if (tmr_exp) begin
        fail = 1'b1; fcode = E_SEL_PINS;
      end
      ST_RST_LO: if (!nstatus_pin_i) begin
        pin_d.nconfig = 1'b1; state_d = ST_RST_HI; tmr_load = 1'b1;
      end else if (tmr_exp) begin
        fail = 1'b1; fcode = E_NS_LO_TMO;
      end
      ST_RST_HI: if (nstatus_pin_i) state_d = ST_RST_CHK;
                 else if (tmr_exp) begin fail = 1'b1; fcode = E_NS_HI_TMO; end
      ST_RST_CHK: if (conf_done_pin_i) begin
        fail = 1'b1; fcode = E_CD_EARLY;
      end else if (!conf_done_oe_i) begin
        fail = 1'b1; fcode = E_CD_OE;
      end else begin
        pin_d.data_en = 1'b1; pin_d.ctrl_en = 1'b1;
        state_d = ST_WAIT_CD; tmr_load = 1'b1;
      end
      // CONF_DONE takes priority over a same-cycle status drop
      ST_WAIT_CD: if (conf_done_pin_i) begin
        state_d = ST_DCLK; dclk_go = 1'b1;
      end else if (!nstatus_pin_i) begin
        fail = 1'b1; fcode = E_NS_DROP;
      end else if (tmr_exp) begin
        fail = 1'b1; fcode = E_CD_TMO;
      end
      ST_DCLK: if (dclk_done) begin state_d = ST_WAIT_UM; tmr_load = 1'b1; end
      ST_WAIT_UM: if (user_mode_i) state_d = ST_RELEASE;
                  else if (tmr_exp) begin fail = 1'b1; fcode = E_UM_TMO; end
      ST_RELEASE: begin
        pin_d   = PINS_REST;
        state_d = ST_FINAL;
      end
      ST_FINAL: begin
        state_d = ST_IDLE;
        if (user_mode_i && conf_done_pin_i && nstatus_pin_i) done_d = 1'b1;
        else err_d = E_FINAL;
      end
      default: state_d = ST_IDLE;
    endcase
    if (fail) begin
      err_d   = fcode;
      pin_d   = PINS_REST;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= E_NONE;
      done_q  <= 1'b0;
      pin_q   <= PINS_REST;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      done_q  <= done_d;
      pin_q   <= pin_d;
    end
  end

  assign ovr_o     = pin_q.ovr;
  assign nconfig_o = pin_q.nconfig;
  assign nce_o     = pin_q.nce;
  assign data_en_o = pin_q.data_en;
  assign ctrl_en_o = pin_q.ctrl_en;
  assign pr_req_o  = 1'b0;
  assign ns_oe_o   = 1'b0;
  assign cd_oe_o   = 1'b0;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  AST_MSEL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MSEL && msel_i > 3'd1) |=> (err_o == E_MSEL && !ovr_o)); // R1
  AST_OVR_AFTER_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(nconfig_pin_i && nstatus_pin_i, 2)); // R2
  AST_NCE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nce_o) |-> (ovr_o && $past(ovr_o) && nconfig_o && !data_en_o && !ctrl_en_o)); // R3
  AST_NCFG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(nconfig_o) && ovr_o) |-> !$past(nstatus_pin_i)); // R4
  AST_EN_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_en_o) |-> (!$past(conf_done_pin_i) && $past(conf_done_oe_i) && nconfig_o)); // R5
  AST_DROP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_CD && !conf_done_pin_i && !nstatus_pin_i)
      |=> (err_o == E_NS_DROP && !data_en_o)); // R6
  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o == E_NONE && !ovr_o && nce_o)); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(err_o) && $stable(done_o))); // R10
endmodule

// File: tb/cfg_seq_test.sv
`timescale 1ns/1ps
module cfg_seq_test;
  localparam int TMO   = 64;
  localparam int CD_AT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] msel = 3'd0;
  logic ncfg_line, ns_pin, cd_pin, cd_oe, um;
  logic ovr_o, nconfig_o, nce_o, pr_req_o, ns_oe_o, cd_oe_o;
  logic data_en_o, ctrl_en_o, dclk_o, busy_o, done_o;
  logic [3:0] err_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // fault flags
  bit f_ext_low = 0, f_ns_nce = 0, f_ns_hi = 0, f_norec = 0, f_cd_early = 0;
  bit f_oe_bad = 0, f_drop = 0, f_cd_stuck = 0, f_um_never = 0, f_um_glitch = 0;
  int drop_at = 0;

  always #2.5 clk = ~clk;

  cfg_seq #(.TIMEOUT(TMO), .PULSES(15)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msel_i(msel),
    .nconfig_pin_i(ncfg_line), .nstatus_pin_i(ns_pin), .conf_done_pin_i(cd_pin),
    .conf_done_oe_i(cd_oe), .user_mode_i(um), .ovr_o, .nconfig_o, .nce_o,
    .pr_req_o, .ns_oe_o, .cd_oe_o, .data_en_o, .ctrl_en_o, .dclk_o,
    .busy_o, .done_o, .err_o
  );

  // target model
  logic [1:0] ns_sh = 2'b11;
  logic       norec_q = 1'b0;
  logic [7:0] dcnt = 8'd0;
  logic [4:0] pc = 5'd0;
  logic       drop_now;

  assign ncfg_line = f_ext_low ? 1'b0 : (ovr_o ? nconfig_o : 1'b1);
  assign drop_now  = f_drop && data_en_o && (int'(dcnt) == drop_at);
  assign ns_pin    = f_ns_hi ? 1'b1 :
                     norec_q ? 1'b0 :
                     (f_ns_nce && ovr_o && !nce_o) ? 1'b0 :
                     drop_now ? 1'b0 : ns_sh[1];
  assign cd_pin    = f_cd_early ? 1'b1 : (f_cd_stuck ? 1'b0 : (int'(dcnt) >= CD_AT));
  assign cd_oe     = !f_oe_bad;
  assign um        = !f_um_never && (pc >= 5'd15) && !(f_um_glitch && !ovr_o);

  always @(posedge clk) begin
    ns_sh <= {ns_sh[0], ncfg_line};
    if (start && !busy_o) begin
      norec_q <= 1'b0; dcnt <= 8'd0; pc <= 5'd0;
    end else begin
      if (f_norec && !ncfg_line && ovr_o) norec_q <= 1'b1;
      if (data_en_o && dcnt != 8'hff) dcnt <= dcnt + 8'd1;
      if (dclk_o && pc != 5'd31) pc <= pc + 5'd1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edge monitors, sampled at negedge
  int  n_dclk = 0;
  bit  dclk_pair = 0, ovr_seen = 0;
  logic p_nce = 1, p_ovr = 0, p_ncfg = 1, p_den = 0, p_cen = 0, p_dclk = 0;
  logic p_ns = 1, p_cd = 0, p_oe = 1;
  always @(negedge clk) if (rst_n) begin
    if (p_nce && !nce_o)
      chk("R3 order", int'({p_ovr, p_ncfg, p_den, p_cen, ovr_o, nconfig_o}), 6'b110011);
    if (ovr_o && !p_ncfg && nconfig_o) chk("R4 status low before release", int'(p_ns), 0);
    if (data_en_o && !p_den)
      chk("R5 enables after checks", int'({p_cd, p_oe, ctrl_en_o}), 3'b011);
    if (pr_req_o || ns_oe_o || cd_oe_o) chk("R3 held low", 1, 0);
    if (dclk_o) n_dclk++;
    if (dclk_o && p_dclk) dclk_pair = 1;
    if (ovr_o) ovr_seen = 1;
    p_nce = nce_o; p_ovr = ovr_o; p_ncfg = nconfig_o; p_den = data_en_o;
    p_cen = ctrl_en_o; p_dclk = dclk_o; p_ns = ns_pin; p_cd = cd_pin; p_oe = cd_oe;
  end

  task automatic clear_faults();
    f_ext_low = 0; f_ns_nce = 0; f_ns_hi = 0; f_norec = 0; f_cd_early = 0;
    f_oe_bad = 0; f_drop = 0; f_cd_stuck = 0; f_um_never = 0; f_um_glitch = 0;
  endtask

  task automatic run(input string req, input int m, input int exp_err,
                     input bit mid_start, output int cyc);
    msel = 3'(m);
    n_dclk = 0; dclk_pair = 0; ovr_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 30) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk({req, " err"}, int'(err_o), exp_err);
    chk({req, " done"}, int'(done_o), (exp_err == 0) ? 1 : 0);
    if (exp_err == 0) begin
      chk("R7 dclk count", n_dclk, 15);
      chk("R7 dclk spacing", int'(dclk_pair), 0);
      chk("R8 released", int'({ovr_o, nce_o, data_en_o, ctrl_en_o}), 4'b0100);
    end else begin
      chk("R10 pins released", int'({ovr_o, nce_o, nconfig_o, data_en_o, ctrl_en_o}), 5'b01100);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset state", int'({busy_o, done_o, err_o, ovr_o, nce_o, nconfig_o}),
        {3'b000, 4'd0, 3'b011});

    // R1: sweep all mode-select values
    for (int m = 0; m < 8; m++) begin
      clear_faults();
      run("R1 msel", m, (m < 2) ? 0 : 1, 0, cyc);
      if (m >= 2) chk("R1 no override", int'(ovr_seen), 0);
    end

    clear_faults(); f_ext_low = 1;
    run("R2 idle wait timeout", 0, 2, 0, cyc);
    chk("R2 waited full timeout", int'(cyc >= TMO), 1);
    f_ext_low = 0;
    repeat (25) @(negedge clk);
    chk("R10 error held", int'(err_o), 2);

    clear_faults(); f_ns_nce = 1;
    run("R2 select wait timeout", 1, 3, 0, cyc);

    clear_faults(); f_ns_hi = 1;
    run("R4 status low timeout", 0, 4, 0, cyc);

    clear_faults(); f_norec = 1;
    run("R4 status high timeout", 0, 5, 0, cyc);

    clear_faults(); f_cd_early = 1;
    run("R5 conf done early", 0, 6, 0, cyc);

    clear_faults(); f_oe_bad = 1;
    run("R5 conf done oe low", 0, 7, 0, cyc);

    clear_faults(); f_drop = 1; drop_at = 10;
    run("R6 status drop", 0, 8, 0, cyc);

    clear_faults(); f_cd_stuck = 1;
    run("R6 conf done timeout", 0, 9, 0, cyc);

    clear_faults(); f_drop = 1; drop_at = CD_AT;
    run("R6 same-cycle drop and conf done", 1, 0, 0, cyc);

    clear_faults(); f_um_never = 1;
    run("R8 user mode timeout", 0, 10, 0, cyc);

    clear_faults(); f_um_glitch = 1;
    run("R9 final check", 0, 11, 0, cyc);

    clear_faults();
    run("R10 start during run ignored", 0, 0, 1, cyc);
    repeat (25) @(negedge clk);
    chk("R9 done held", int'({done_o, err_o}), 5'b10000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule